// File: doc/BRIEF.md
# Table Branch Execution Unit

This unit executes the table-branch instruction of a 32-bit instruction set in its byte-entry and halfword-entry variants. The issue stage hands it the instruction word, the values of the base and index registers, the address of the instruction and a condition-pass bit. The unit checks the encoding and forms the table address from base and index, scaled by the entry size. It reads one entry over a data-memory port, zero-extends it, and sends out a forward branch target equal to the instruction address plus four plus twice the entry.

The core is a single state machine. `ST_IDLE` accepts an instruction when `issue_valid` is high. From `ST_IDLE`, an illegal encoding takes the transition to `ST_FAULT`. A legal instruction whose condition failed goes to `ST_SKIP`. Otherwise the machine goes to `ST_REQ`. `ST_REQ` holds the memory request until `mem_gnt` arrives, then moves to `ST_WAIT`. `ST_WAIT` waits for `mem_rvalid` and moves to `ST_BRANCH`. `ST_BRANCH`, `ST_FAULT` and `ST_SKIP` each last one cycle and return to `ST_IDLE`. The unit takes no new instruction outside `ST_IDLE`. It never touches condition flags.

Top module: `tblbr_unit`

## Requirements
- R1: An instruction is a table branch only when `(instr & 32'hFFF0_FFE0) == 32'hE8D0_F000`. Any other word raises `fault` for exactly one cycle, the cycle after acceptance, with no memory request and no branch.
- R2: A table-branch word whose index register field (bits 3:0) equals 15 is illegal and is handled as in R1.
- R3: With bit 4 set (halfword form), the request carries `mem_addr = base + (index << 1)` and `mem_size = 1`, and the entry is `mem_rdata[15:0]`.
- R4: With bit 4 clear (byte form), the request carries `mem_addr = base + index` and `mem_size = 0`, and the entry is `mem_rdata[7:0]` zero-extended. Bits 15:8 are ignored.
- R5: `br_target = (pc + 4 + 2*entry) mod 2^32` with bit 0 forced to zero. The entry is treated as unsigned.
- R6: A legal instruction accepted with `issue_cond` low makes no memory request and no branch, and pulses `skipped` for one cycle, the cycle after acceptance.
- R7: `mem_req` stays high with stable `mem_addr` and `mem_size` until `mem_gnt`. `issue_ready` stays low from acceptance until the unit is back in idle, and instructions offered meanwhile are not taken.
- R8: `br_valid` is high for exactly one cycle, the cycle after `mem_rvalid` is sampled.
- R9: An odd halfword table address is sent unchanged, with no fault.
- R10: Synchronous active-high `rst` returns the unit to idle: `issue_ready` high, and `mem_req`, `br_valid`, `fault` and `skipped` low.
- R11: An illegal encoding faults (R1, R2) even when `issue_cond` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle, accepts offer this cycle |
| issue_instr | input | 32 | Instruction word |
| issue_base | input | AW | Base register value |
| issue_index | input | AW | Index register value |
| issue_pc | input | AW | Address of the instruction |
| issue_cond | input | 1 | Condition passed |
| mem_req | output | 1 | Table read request |
| mem_gnt | input | 1 | Request taken by memory |
| mem_addr | output | AW | Table byte address |
| mem_size | output | 1 | 0 = byte, 1 = halfword |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | EW | Read data, byte in low lane |
| br_valid | output | 1 | Branch target valid pulse |
| br_target | output | AW | Branch target |
| fault | output | 1 | Illegal-encoding pulse |
| skipped | output | 1 | Condition-failed completion pulse |

## Verification
The bound checker applies several rules on every cycle. A pending request keeps its address and size, and the unit is never ready while a request is out. `br_valid` lasts one cycle and follows `mem_rvalid`. The target is even, and the three completion pulses never overlap a request or each other. Other behaviour only shows up in the bench's scenarios. These include the exact addresses for byte and halfword scaling, the zero extension that drops the upper byte, wrap-around of address and target, and decoding of malformed words and of index 15. They also cover fault priority over a failed condition, and refusing offers held high while busy, which the scoreboard exposes through the ordering of requests and results.

// File: rtl/tblbr_pkg.sv
package tblbr_pkg;

    localparam int unsigned INSN_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_BRANCH,
        ST_FAULT,
        ST_SKIP
    } tb_state_e;

    typedef struct packed {
        logic legal;
        logic half;
        logic [3:0] idx_reg;
    } tb_decode_t;

endpackage

// File: rtl/tblbr_decode.sv
module tblbr_decode
    import tblbr_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output tb_decode_t        dec
);
    localparam logic [11:0] OPC_HI   = 12'hE8D;
    localparam logic [3:0]  OPC_MID  = 4'hF;
    localparam logic [6:0]  OPC_ZERO = 7'd0;
    localparam logic [3:0]  REG_PC   = 4'd15;

    logic pattern_ok;
    logic unused_base_field;

    assign unused_base_field = ^instr[19:16];

    always_comb begin
        pattern_ok  = (instr[31:20] == OPC_HI)
                   && (instr[15:12] == OPC_MID)
                   && (instr[11:5]  == OPC_ZERO);
        dec.half    = instr[4];
        dec.idx_reg = instr[3:0];
        dec.legal   = pattern_ok && (instr[3:0] != REG_PC);
    end
endmodule

// File: rtl/tblbr_agen.sv
module tblbr_agen #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic          half,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] offset;

    always_comb begin
        offset = half ? {index[AW-2:0], 1'b0} : index;
        addr   = base + offset;
    end
endmodule

// File: rtl/tblbr_target.sv
module tblbr_target #(
    parameter int unsigned AW = 32,
    parameter int unsigned EW = 16
) (
    input  logic [AW-1:0] ret_addr,
    input  logic [EW-1:0] rdata,
    input  logic          half,
    output logic [AW-1:0] target
);
    localparam int unsigned BYTE_W = 8;

    logic [EW-1:0] entry;
    logic [AW-1:0] entry_ext;
    logic [AW-1:0] sum;

    always_comb begin
        entry     = half ? rdata : {{(EW-BYTE_W){1'b0}}, rdata[BYTE_W-1:0]};
        entry_ext = {{(AW-EW){1'b0}}, entry};
        sum       = ret_addr + {entry_ext[AW-2:0], 1'b0};
        target    = {sum[AW-1:1], 1'b0};
    end
endmodule

// File: rtl/tblbr_unit.sv
module tblbr_unit
    import tblbr_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned EW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_valid,
    output logic          issue_ready,
    input  logic [31:0]   issue_instr,
    input  logic [AW-1:0] issue_base,
    input  logic [AW-1:0] issue_index,
    input  logic [AW-1:0] issue_pc,
    input  logic          issue_cond,
    output logic          mem_req,
    input  logic          mem_gnt,
    output logic [AW-1:0] mem_addr,
    output logic          mem_size,
    input  logic          mem_rvalid,
    input  logic [EW-1:0] mem_rdata,
    output logic          br_valid,
    output logic [AW-1:0] br_target,
    output logic          fault,
    output logic          skipped
);
    localparam logic [AW-1:0] PC_STEP = AW'(4);

    tb_state_e     state_q, state_d;
    tb_decode_t    dec;
    logic          accept;
    logic [AW-1:0] agen_addr;
    logic [AW-1:0] tgt_calc;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] ret_q;
    logic [AW-1:0] target_q;
    logic          half_q;

    tblbr_decode u_dec (
        .instr (issue_instr),
        .dec   (dec)
    );

    tblbr_agen #(.AW(AW)) u_agen (
        .base  (issue_base),
        .index (issue_index),
        .half  (dec.half),
        .addr  (agen_addr)
    );

    tblbr_target #(.AW(AW), .EW(EW)) u_tgt (
        .ret_addr (ret_q),
        .rdata    (mem_rdata),
        .half     (half_q),
        .target   (tgt_calc)
    );

    assign accept = issue_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!dec.legal)      state_d = ST_FAULT;
                    else if (!issue_cond) state_d = ST_SKIP;
                    else                  state_d = ST_REQ;
                end
            end
            ST_REQ:    if (mem_gnt)    state_d = ST_WAIT;
            ST_WAIT:   if (mem_rvalid) state_d = ST_BRANCH;
            ST_BRANCH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            ST_SKIP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            ret_q    <= '0;
            half_q   <= 1'b0;
            target_q <= '0;
        end else begin
            if (accept) begin
                addr_q <= agen_addr;
                half_q <= dec.half;
                ret_q  <= issue_pc + PC_STEP;
            end
            if ((state_q == ST_WAIT) && mem_rvalid)
                target_q <= tgt_calc;
        end
    end

    always_comb begin
        issue_ready = (state_q == ST_IDLE);
        mem_req     = (state_q == ST_REQ);
        mem_addr    = addr_q;
        mem_size    = half_q;
        br_valid    = (state_q == ST_BRANCH);
        br_target   = target_q;
        fault       = (state_q == ST_FAULT);
        skipped     = (state_q == ST_SKIP);
    end
endmodule

// File: rtl/tblbr_unit_chk.sv
module tblbr_unit_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          issue_ready,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          mem_size,
    input logic          mem_rvalid,
    input logic          br_valid,
    input logic [AW-1:0] br_target,
    input logic          fault,
    input logic          skipped
);
    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_size)));

    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !issue_ready);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> !br_valid);

    a_r8_after_data: assert property (@(posedge clk) disable iff (rst)
        br_valid |-> $past(mem_rvalid));

    a_r5_target_even: assert property (@(posedge clk) disable iff (rst)
        br_valid |-> !br_target[0]);

    a_r1_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!mem_req && !br_valid));

    a_r1_fault_pulse: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);

    a_r6_skip_quiet: assert property (@(posedge clk) disable iff (rst)
        skipped |=> (!skipped && !mem_req));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({br_valid, fault, skipped, mem_req}));

    a_r10_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (issue_ready && !mem_req && !br_valid && !fault && !skipped));
endmodule

bind tblbr_unit tblbr_unit_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_ready (issue_ready),
    .mem_req     (mem_req),
    .mem_gnt     (mem_gnt),
    .mem_addr    (mem_addr),
    .mem_size    (mem_size),
    .mem_rvalid  (mem_rvalid),
    .br_valid    (br_valid),
    .br_target   (br_target),
    .fault       (fault),
    .skipped     (skipped)
);

// File: tb/tblbr_unit_test.sv
`timescale 1ns/1ps
module tblbr_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [31:0] issue_instr = '0;
    logic [31:0] issue_base = '0;
    logic [31:0] issue_index = '0;
    logic [31:0] issue_pc = '0;
    logic        issue_cond = 1'b0;
    logic        mem_req;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_size;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        br_valid;
    logic [31:0] br_target;
    logic        fault;
    logic        skipped;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // expected completions: 0 branch, 1 fault, 2 skip
    int          ek_q[$];
    logic [31:0] ev_q[$];
    string       et_q[$];
    // expected memory requests and responses
    logic [31:0] ra_q[$];
    logic        rs_q[$];
    logic [15:0] rd_q[$];
    int          gd_q[$];
    int          vd_q[$];
    string       rt_q[$];

    always #2 clk = ~clk;

    tblbr_unit uut (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_instr(issue_instr), .issue_base(issue_base),
        .issue_index(issue_index), .issue_pc(issue_pc), .issue_cond(issue_cond),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .br_valid(br_valid), .br_target(br_target), .fault(fault), .skipped(skipped)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // driver: computes expectations from the requirements and offers the instruction
    task automatic run_op(input logic [31:0] ins, input logic [31:0] base, input logic [31:0] idx,
                          input logic [31:0] pc, input logic cond, input logic [15:0] data,
                          input int gd, input int vd, input string tag);
        bit legal;
        logic [15:0] ent;
        legal = ((ins & 32'hFFF0_FFE0) == 32'hE8D0_F000) && (ins[3:0] != 4'hF);
        if (!legal) begin
            ek_q.push_back(1); ev_q.push_back('0); et_q.push_back(tag);
        end else if (!cond) begin
            ek_q.push_back(2); ev_q.push_back('0); et_q.push_back(tag);
        end else begin
            ent = ins[4] ? data : {8'h00, data[7:0]};
            ra_q.push_back(ins[4] ? base + idx * 2 : base + idx);
            rs_q.push_back(ins[4]);
            rd_q.push_back(data); gd_q.push_back(gd); vd_q.push_back(vd); rt_q.push_back(tag);
            ek_q.push_back(0);
            ev_q.push_back((pc + 32'd4 + {15'd0, ent, 1'b0}) & 32'hFFFF_FFFE);
            et_q.push_back(tag);
        end
        issue_valid = 1'b1; issue_instr = ins; issue_base = base;
        issue_index = idx; issue_pc = pc; issue_cond = cond;
        while (!issue_ready) @(negedge clk);
        @(negedge clk);
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && mem_req) begin
                if (ra_q.size() == 0) begin
                    check(0, "R7 unexpected request", mem_addr, '0);
                end else begin
                    logic [31:0] ea; logic es; logic [15:0] d; int g; int v; string t;
                    ea = ra_q.pop_front(); es = rs_q.pop_front(); d = rd_q.pop_front();
                    g = gd_q.pop_front(); v = vd_q.pop_front(); t = rt_q.pop_front();
                    check(mem_addr == ea, {t, " R3 R4 R9 address"}, mem_addr, ea);
                    check(mem_size == es, {t, " R3 R4 size"}, {31'd0, mem_size}, {31'd0, es});
                    for (int i = 0; i < g; i++) begin
                        @(negedge clk);
                        check(mem_req && mem_addr == ea, {t, " R7 request held"}, mem_addr, ea);
                    end
                    mem_gnt = 1'b1;
                    @(negedge clk);
                    mem_gnt = 1'b0;
                    for (int i = 0; i < v; i++) begin
                        @(negedge clk);
                        check(!br_valid && !mem_req, {t, " R8 no early branch"}, {31'd0, br_valid}, '0);
                    end
                    mem_rvalid = 1'b1; mem_rdata = d;
                    @(negedge clk);
                    mem_rvalid = 1'b0; mem_rdata = 16'hDEAD;
                    check(br_valid, {t, " R8 branch after data"}, {31'd0, br_valid}, 32'd1);
                end
            end
        end
    end

    // monitor / scoreboard
    initial begin
        bit prev_bv = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (br_valid && prev_bv) check(0, "R8 pulse too long", 32'd1, 32'd0);
                if (mem_req && issue_ready) check(0, "R7 ready while busy", 32'd1, 32'd0);
                if (br_valid || fault || skipped) begin
                    int k;
                    k = br_valid ? 0 : (fault ? 1 : 2);
                    if (ek_q.size() == 0) begin
                        check(0, "R1 R6 unexpected completion", k, 32'hFFFF_FFFF);
                    end else begin
                        int ek; logic [31:0] ev; string t;
                        ek = ek_q.pop_front(); ev = ev_q.pop_front(); t = et_q.pop_front();
                        check(k == ek, {t, " kind"}, k, ek);
                        if (ek == 0 && k == 0) check(br_target == ev, {t, " R5 target"}, br_target, ev);
                    end
                end
                prev_bv = br_valid;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(issue_ready && !mem_req && !br_valid && !fault && !skipped,
              "R10 reset idle", {27'd0, issue_ready, mem_req, br_valid, fault, skipped}, 32'h10);
        rst = 1'b0;
        @(negedge clk);
        // halfword, nominal
        run_op(32'hE8D1_F012, 32'h0000_1000, 32'd3, 32'h0000_0200, 1, 16'h0010, 0, 0, "R3 half");
        // byte form, high byte must be ignored
        run_op(32'hE8D3_F005, 32'h0000_2000, 32'd5, 32'h0000_0300, 1, 16'hAB7F, 2, 1, "R4 byte");
        // byte entry zero
        run_op(32'hE8D2_F004, 32'h0000_2100, 32'd0, 32'h0000_0400, 1, 16'hFF00, 1, 3, "R4 byte zero");
        // max halfword entry
        run_op(32'hE8D1_F012, 32'h0000_1000, 32'd1, 32'h0000_0100, 1, 16'hFFFF, 0, 2, "R5 max entry");
        // target wrap
        run_op(32'hE8D4_F016, 32'h0000_4000, 32'd7, 32'hFFFF_FFF0, 1, 16'h0020, 3, 0, "R5 target wrap");
        // odd pc: bit0 cleared
        run_op(32'hE8D1_F012, 32'h0000_1000, 32'd2, 32'h0000_0201, 1, 16'h0003, 0, 0, "R5 bit0 clear");
        // odd halfword address
        run_op(32'hE8D5_F012, 32'h0000_3001, 32'd2, 32'h0000_0500, 1, 16'h0004, 1, 1, "R9 odd address");
        // address wrap
        run_op(32'hE8D5_F012, 32'hFFFF_FFFE, 32'd2, 32'h0000_0600, 1, 16'h0001, 0, 0, "R3 address wrap");
        // index register 15
        run_op(32'hE8D0_F01F, 32'h0000_1000, 32'd1, 32'h0000_0700, 1, 16'h0000, 0, 0, "R2 index pc");
        // malformed words
        run_op(32'hE8D0_F110, 32'h0000_1000, 32'd1, 32'h0000_0800, 1, 16'h0000, 0, 0, "R1 bit8 set");
        run_op(32'hE8D0_E010, 32'h0000_1000, 32'd1, 32'h0000_0800, 1, 16'h0000, 0, 0, "R1 bits15_12");
        run_op(32'hE9D0_F010, 32'h0000_1000, 32'd1, 32'h0000_0800, 1, 16'h0000, 0, 0, "R1 opcode");
        // condition fails
        run_op(32'hE8D0_F010, 32'h0000_1000, 32'd1, 32'h0000_0900, 0, 16'h0000, 0, 0, "R6 cond fail");
        // illegal wins over condition fail
        run_op(32'hE8D0_F01F, 32'h0000_1000, 32'd1, 32'h0000_0900, 0, 16'h0000, 0, 0, "R11 fault priority");
        // back to back with long stalls while next offer is held (R7)
        run_op(32'hE8D6_F013, 32'h0000_8000, 32'd9, 32'h0000_0A00, 1, 16'h1234, 5, 6, "R7 stall one");
        run_op(32'hE8D6_F003, 32'h0000_8000, 32'd9, 32'h0000_0B00, 1, 16'h5680, 4, 4, "R7 stall two");
        issue_valid = 1'b0;
        for (int i = 0; i < 200 && (ek_q.size() != 0 || ra_q.size() != 0); i++) @(negedge clk);
        repeat (5) @(negedge clk);
        check(ek_q.size() == 0 && ra_q.size() == 0, "R7 all results drained",
              ek_q.size() + ra_q.size(), 32'd0);
        check(issue_ready && !mem_req, "R10 idle at end", {30'd0, issue_ready, mem_req}, 32'd2);
        finish_run();
    end
endmodule